// File: doc/BRIEF.md
# Fixed-Head Disk Controller Register File

This block is the register set that a processor sees for a fixed-head disk controller. Eight 16-bit registers sit behind a 3-bit select (word address bits 3:1): a rotating look-ahead position, the disk address, a sticky error-status word, the command/status word, the word count, the current memory address, a maintenance word and the last data word. The register set handles whole-word and single-byte writes. It keeps the done, error-summary and interrupt state. It checks the unit field of each disk address against the number of fitted platters. When a command is started, it fires a one-cycle start pulse towards a separate transfer engine.

The engine reads the disk address, word count, memory address, extension bits and increment-inhibit flag from this block. When it finishes, it raises a one-cycle completion strobe. With that strobe it returns error flags and the updated disk address, word count, memory address, extension bits and data word. The register set then sets done and, when enabled, requests an interrupt. The disk medium, the memory path and the checksum logic are all outside this block.

Top module: `fhd_regs`

## Requirements
- R1: After reset, the command/status register reads 0x0080 (done only) and every other register reads 0. The interrupt request and the start pulse are low.
- R2: The command/status read layout is: 15 error summary, 14 data error, 13 address error, 12 write lock, 11 missing unit, 10 compare error, 9 increment inhibit, 8 abort, 7 done, 6 interrupt enable, 5:4 memory extension, 3 maintenance, 2:1 function, 0 go. Bits 8 and 0 always read 0. Bit 15 is never written; it reads 1 exactly when any of bits 14..10 is set or the error-status register is non-zero.
- R3: For the word-count, disk-address and command/status registers, a byte write carries its byte in write-data bits 7:0. With the address bit 0 input at 1 it replaces bits 15:8; at 0 it replaces bits 7:0.
- R4: Writes to the look-ahead (select 0), error-status (select 2) and data (select 7) registers have no effect. The memory-address register (select 5) stores write bits 15:1 with bit 0 held at 0. The maintenance register (select 6) stores bits 15:6 with bits 5:0 held at 0. Both take the full write word even on byte writes.
- R5: A disk-address write (select 1) stores 13 bits and first clears the missing-unit flag (status bit 11). If the unit field (bits 12:11) is at least NUM_PLATTERS, the missing-unit flag is set. Otherwise the value is also copied into the look-ahead register.
- R6: A look-ahead read returns its 13 bits in 12:0. Bit 15 is set when the missing-unit flag or the overflow bit (error-status bit 5) is set. After each read, bits 5:0 step by one modulo 64 and bits 12:6 are kept.
- R7: A command/status write with go=1 is taken only while done is set; otherwise no start occurs. Taking it clears bits 14..10, done, the error-status register and the interrupt request. On the following clock edge it raises the start output for exactly one cycle, with the written function on the function output.
- R8: A command/status write with the abort bit set forces done to 1 and pulses the abort output for one cycle.
- R9: The interrupt request rises when done goes 0 to 1 while interrupt enable is set. It also rises when interrupt enable is written 0 to 1 while done is set. Writing interrupt enable as 0 drops it.
- R10: A completion strobe sets done and ORs the returned flags into status bits 14..10 and into the error-status register. It loads the disk address, word count, memory address (bit 0 forced 0), extension bits and data word. It also copies the new disk address into look-ahead unless the function is 0 (position sensing only).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_sel | input | 3 | Register select (word address bits 3:1) |
| bus_hi | input | 1 | Address bit 0; picks the byte lane on byte writes |
| bus_byte | input | 1 | 1 for a byte write, 0 for a word write |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe (advances look-ahead on select 0) |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data for the selected register |
| eng_start | output | 1 | One-cycle start pulse to the transfer engine |
| eng_abort | output | 1 | One-cycle cancel pulse to the transfer engine |
| eng_func | output | 2 | Current function code |
| eng_da | output | DA_W | Disk address |
| eng_wc | output | 16 | Word count |
| eng_ca | output | 16 | Memory address |
| eng_mex | output | 2 | Memory extension bits |
| eng_inh | output | 1 | Memory address increment inhibit |
| cmp_valid | input | 1 | Completion strobe from the engine |
| cmp_cs_err | input | 5 | Flags ORed into status bits 14..10 |
| cmp_er | input | 16 | Flags ORed into the error-status register |
| cmp_da | input | DA_W | Updated disk address |
| cmp_wc | input | 16 | Updated word count |
| cmp_ca | input | 16 | Updated memory address |
| cmp_mex | input | 2 | Updated memory extension bits |
| cmp_db | input | 16 | Last data word |
| irq | output | 1 | Interrupt request |

## Verification
On every cycle, the assertions check several properties. A start always leaves done and the status error bits clear. The interrupt request never stands without interrupt enable, and it follows a rise of done whenever enable is held. An abort that does not also start leaves done set. The error summary reflects a non-zero error-status register. Each look-ahead read steps only the low six bits. After any disk-address write, the missing-unit flag matches the unit field. Writes to the read-only registers leave their contents alone. Only the bench scenarios can show the rest: the exact byte-lane merges, the masks on the address and maintenance registers, go being refused while busy, the full 64-step wrap of the look-ahead counter, a sweep of all four unit values against a two-platter setting, and the register contents after completion for both a transfer function and the position-only function.

// File: rtl/fhd_pkg.sv
package fhd_pkg;

  localparam int DW = 16;

  // register selects (word address bits 3:1)
  localparam logic [2:0] SEL_LA = 3'd0;
  localparam logic [2:0] SEL_DA = 3'd1;
  localparam logic [2:0] SEL_ER = 3'd2;
  localparam logic [2:0] SEL_CS = 3'd3;
  localparam logic [2:0] SEL_WC = 3'd4;
  localparam logic [2:0] SEL_CA = 3'd5;
  localparam logic [2:0] SEL_MN = 3'd6;
  localparam logic [2:0] SEL_DB = 3'd7;
  localparam int NUM_SEL = 8;

  // command/status bit positions
  localparam int CS_INH  = 9;
  localparam int CS_ABT  = 8;
  localparam int CS_DONE = 7;
  localparam int CS_IE   = 6;
  localparam int CS_MNT  = 3;
  localparam int CS_GO   = 0;
  localparam int NERR    = 5;   // status bits 14..10
  localparam int ERRF_NED = 1;  // index of bit 11 inside the 5-bit error field

  localparam int ER_OVFL = 5;   // overflow bit in error-status register
  localparam int MN_LSB  = 6;   // lowest kept bit of maintenance register

  function automatic logic [DW-1:0] byte_merge(input logic [DW-1:0] cur,
                                               input logic [DW-1:0] wd,
                                               input logic          byte_en,
                                               input logic          hi);
    logic [DW-1:0] r;
    if (!byte_en)  r = wd;
    else if (hi)   r = {wd[7:0], cur[7:0]};
    else           r = {cur[15:8], wd[7:0]};
    return r;
  endfunction

endpackage

// File: rtl/fhd_ctl.sv
module fhd_ctl
  import fhd_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic            cs_wr,
  input  logic [DW-1:0]   cs_wd,
  input  logic            ned_clr,
  input  logic            ned_set,
  input  logic            cmp_valid,
  input  logic [NERR-1:0] cmp_err,
  input  logic [1:0]      cmp_mex,
  input  logic            er_any,
  output logic [DW-1:0]   cs_rd,
  output logic            go_take,
  output logic            done,
  output logic            ned,
  output logic            inh,
  output logic [1:0]      mex,
  output logic [1:0]      func,
  output logic            start,
  output logic            abort,
  output logic            irq
);

  logic [NERR-1:0] err_q, err_n;
  logic            inh_q, inh_n;
  logic            done_q, done_n;
  logic            ie_q, ie_n;
  logic [1:0]      mex_q, mex_n;
  logic            mnt_q, mnt_n;
  logic [1:0]      func_q, func_n;
  logic            start_q, start_n;
  logic            abort_q, abort_n;
  logic            irq_q, irq_n;

  logic unused_cs_bits;
  assign unused_cs_bits = ^{cs_wd[15:10], cs_wd[CS_DONE]};

  // next state: completion first, then the bus write on top of it
  always_comb begin
    err_n   = err_q;
    inh_n   = inh_q;
    done_n  = done_q;
    ie_n    = ie_q;
    mex_n   = mex_q;
    mnt_n   = mnt_q;
    func_n  = func_q;
    irq_n   = irq_q;
    start_n = 1'b0;
    abort_n = 1'b0;
    go_take = 1'b0;

    if (cmp_valid) begin
      if (ie_q && !done_q) irq_n = 1'b1;
      done_n = 1'b1;
      err_n  = err_n | cmp_err;
      mex_n  = cmp_mex;
    end

    if (ned_clr) err_n[ERRF_NED] = 1'b0;
    if (ned_set) err_n[ERRF_NED] = 1'b1;

    if (cs_wr) begin
      if (cs_wd[CS_ABT]) begin
        if (ie_q && !done_n) irq_n = 1'b1;
        done_n  = 1'b1;
        abort_n = 1'b1;
      end
      if (!cs_wd[CS_IE])           irq_n = 1'b0;
      else if (done_n && !ie_q)    irq_n = 1'b1;
      inh_n  = cs_wd[CS_INH];
      ie_n   = cs_wd[CS_IE];
      mex_n  = cs_wd[5:4];
      mnt_n  = cs_wd[CS_MNT];
      func_n = cs_wd[2:1];
      if (done_n && cs_wd[CS_GO]) begin
        go_take = 1'b1;
        err_n   = '0;
        done_n  = 1'b0;
        irq_n   = 1'b0;
        start_n = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      err_q   <= '0;
      inh_q   <= 1'b0;
      done_q  <= 1'b1;
      ie_q    <= 1'b0;
      mex_q   <= '0;
      mnt_q   <= 1'b0;
      func_q  <= '0;
      start_q <= 1'b0;
      abort_q <= 1'b0;
      irq_q   <= 1'b0;
    end else begin
      err_q   <= err_n;
      inh_q   <= inh_n;
      done_q  <= done_n;
      ie_q    <= ie_n;
      mex_q   <= mex_n;
      mnt_q   <= mnt_n;
      func_q  <= func_n;
      start_q <= start_n;
      abort_q <= abort_n;
      irq_q   <= irq_n;
    end
  end

  assign cs_rd = {(err_q != '0) || er_any, err_q, inh_q, 1'b0, done_q, ie_q,
                  mex_q, mnt_q, func_q, 1'b0};
  assign done  = done_q;
  assign ned   = err_q[ERRF_NED];
  assign inh   = inh_q;
  assign mex   = mex_q;
  assign func  = func_q;
  assign start = start_q;
  assign abort = abort_q;
  assign irq   = irq_q;

  AST_START_CLEARS_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    start_q |-> (!done_q && err_q == '0)); // R7
  AST_IRQ_NEEDS_IE: assert property (@(posedge clk) disable iff (!rst_n)
    irq_q |-> ie_q); // R9
  AST_DONE_RISE_IRQ: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(done_q) && ie_q && $past(ie_q)) |-> irq_q); // R9
  AST_ABORT_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    (abort_q && !start_q) |-> done_q); // R8

endmodule

// File: rtl/fhd_addr.sv
module fhd_addr #(
  parameter int NUM_PLATTERS = 4,
  parameter int DA_W         = 13,
  parameter int ROT_W        = 6
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            da_wr,
  input  logic [DA_W-1:0] da_wd,
  input  logic            la_rd,
  input  logic            cmp_valid,
  input  logic            cmp_la_load,
  input  logic [DA_W-1:0] cmp_da,
  output logic [DA_W-1:0] da,
  output logic [DA_W-1:0] la,
  output logic            ned_clr,
  output logic            ned_set
);

  localparam int UNIT_LSB = DA_W - 2;

  logic [DA_W-1:0] da_q, da_n;
  logic [DA_W-1:0] la_q, la_n;
  logic [1:0]      unit;
  logic            bad_unit;

  assign unit     = da_wd[DA_W-1:UNIT_LSB];
  assign bad_unit = int'(unit) >= NUM_PLATTERS;
  assign ned_clr  = da_wr;
  assign ned_set  = da_wr && bad_unit;

  always_comb begin
    da_n = da_q;
    la_n = la_q;
    if (la_rd) la_n[ROT_W-1:0] = la_q[ROT_W-1:0] + ROT_W'(1);
    if (cmp_valid) begin
      da_n = cmp_da;
      if (cmp_la_load) la_n = cmp_da;
    end
    if (da_wr) begin
      da_n = da_wd;
      if (!bad_unit) la_n = da_wd;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      da_q <= '0;
      la_q <= '0;
    end else begin
      da_q <= da_n;
      la_q <= la_n;
    end
  end

  assign da = da_q;
  assign la = la_q;

  AST_LA_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (la_rd && !da_wr && !(cmp_valid && cmp_la_load)) |=>
      (la_q[ROT_W-1:0] == $past(la_q[ROT_W-1:0]) + ROT_W'(1)) &&
      (la_q[DA_W-1:ROT_W] == $past(la_q[DA_W-1:ROT_W]))); // R6

endmodule

// File: rtl/fhd_data.sv
module fhd_data
  import fhd_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wc_wr,
  input  logic          ca_wr,
  input  logic          mn_wr,
  input  logic [DW-1:0] wc_wd,
  input  logic [DW-1:0] raw_wd,
  input  logic          go_take,
  input  logic          cmp_valid,
  input  logic [DW-1:0] cmp_er,
  input  logic [DW-1:0] cmp_wc,
  input  logic [DW-1:0] cmp_ca,
  input  logic [DW-1:0] cmp_db,
  output logic [DW-1:0] wc,
  output logic [DW-1:0] ca,
  output logic [DW-1:0] mn,
  output logic [DW-1:0] db,
  output logic [DW-1:0] er
);

  logic [DW-1:0] wc_q, wc_n, ca_q, ca_n, mn_q, mn_n, db_q, db_n, er_q, er_n;

  logic unused_low;
  assign unused_low = ^{raw_wd[0], cmp_ca[0]};

  always_comb begin
    wc_n = wc_q;
    ca_n = ca_q;
    mn_n = mn_q;
    db_n = db_q;
    er_n = er_q;
    if (cmp_valid) begin
      er_n = er_q | cmp_er;
      wc_n = cmp_wc;
      ca_n = {cmp_ca[DW-1:1], 1'b0};
      db_n = cmp_db;
    end
    if (go_take) er_n = '0;
    if (wc_wr)   wc_n = wc_wd;
    if (ca_wr)   ca_n = {raw_wd[DW-1:1], 1'b0};
    if (mn_wr)   mn_n = {raw_wd[DW-1:MN_LSB], {MN_LSB{1'b0}}};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wc_q <= '0;
      ca_q <= '0;
      mn_q <= '0;
      db_q <= '0;
      er_q <= '0;
    end else begin
      wc_q <= wc_n;
      ca_q <= ca_n;
      mn_q <= mn_n;
      db_q <= db_n;
      er_q <= er_n;
    end
  end

  assign wc = wc_q;
  assign ca = ca_q;
  assign mn = mn_q;
  assign db = db_q;
  assign er = er_q;

endmodule

// File: rtl/fhd_regs.sv
module fhd_regs
  import fhd_pkg::*;
#(
  parameter int NUM_PLATTERS = 4,
  parameter int DA_W         = 13,
  parameter int ROT_W        = 6
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [2:0]      bus_sel,
  input  logic            bus_hi,
  input  logic            bus_byte,
  input  logic            bus_wr,
  input  logic            bus_rd,
  input  logic [15:0]     bus_wdata,
  output logic [15:0]     bus_rdata,
  output logic            eng_start,
  output logic            eng_abort,
  output logic [1:0]      eng_func,
  output logic [DA_W-1:0] eng_da,
  output logic [15:0]     eng_wc,
  output logic [15:0]     eng_ca,
  output logic [1:0]      eng_mex,
  output logic            eng_inh,
  input  logic            cmp_valid,
  input  logic [4:0]      cmp_cs_err,
  input  logic [15:0]     cmp_er,
  input  logic [DA_W-1:0] cmp_da,
  input  logic [15:0]     cmp_wc,
  input  logic [15:0]     cmp_ca,
  input  logic [1:0]      cmp_mex,
  input  logic [15:0]     cmp_db,
  output logic            irq
);

  localparam int PAD_DA = DW - DA_W;
  localparam int PAD_LA = DW - 1 - DA_W;

  logic [NUM_SEL-1:0] wr_hit;
  logic [DW-1:0]      cur_val, merged;
  logic [DW-1:0]      cs_rd, wc_q, ca_q, mn_q, db_q, er_q;
  logic [DA_W-1:0]    da_q, la_q;
  logic               go_take, ned, done, ned_clr, ned_set, la_rd;
  logic [1:0]         func;

  for (genvar g = 0; g < NUM_SEL; g++) begin : g_dec
    assign wr_hit[g] = bus_wr && (bus_sel == 3'(g));
  end

  assign la_rd = bus_rd && (bus_sel == SEL_LA);

  always_comb begin
    case (bus_sel)
      SEL_DA:  cur_val = {{PAD_DA{1'b0}}, da_q};
      SEL_CS:  cur_val = cs_rd;
      default: cur_val = wc_q;
    endcase
  end

  assign merged = byte_merge(cur_val, bus_wdata, bus_byte, bus_hi);

  fhd_ctl u_ctl (
    .clk       (clk),
    .rst_n     (rst_n),
    .cs_wr     (wr_hit[SEL_CS]),
    .cs_wd     (merged),
    .ned_clr   (ned_clr),
    .ned_set   (ned_set),
    .cmp_valid (cmp_valid),
    .cmp_err   (cmp_cs_err),
    .cmp_mex   (cmp_mex),
    .er_any    (er_q != '0),
    .cs_rd     (cs_rd),
    .go_take   (go_take),
    .done      (done),
    .ned       (ned),
    .inh       (eng_inh),
    .mex       (eng_mex),
    .func      (func),
    .start     (eng_start),
    .abort     (eng_abort),
    .irq       (irq)
  );

  fhd_addr #(
    .NUM_PLATTERS (NUM_PLATTERS),
    .DA_W         (DA_W),
    .ROT_W        (ROT_W)
  ) u_addr (
    .clk         (clk),
    .rst_n       (rst_n),
    .da_wr       (wr_hit[SEL_DA]),
    .da_wd       (merged[DA_W-1:0]),
    .la_rd       (la_rd),
    .cmp_valid   (cmp_valid),
    .cmp_la_load (func != 2'b00),
    .cmp_da      (cmp_da),
    .da          (da_q),
    .la          (la_q),
    .ned_clr     (ned_clr),
    .ned_set     (ned_set)
  );

  fhd_data u_data (
    .clk       (clk),
    .rst_n     (rst_n),
    .wc_wr     (wr_hit[SEL_WC]),
    .ca_wr     (wr_hit[SEL_CA]),
    .mn_wr     (wr_hit[SEL_MN]),
    .wc_wd     (merged),
    .raw_wd    (bus_wdata),
    .go_take   (go_take),
    .cmp_valid (cmp_valid),
    .cmp_er    (cmp_er),
    .cmp_wc    (cmp_wc),
    .cmp_ca    (cmp_ca),
    .cmp_db    (cmp_db),
    .wc        (wc_q),
    .ca        (ca_q),
    .mn        (mn_q),
    .db        (db_q),
    .er        (er_q)
  );

  always_comb begin
    case (bus_sel)
      SEL_LA:  bus_rdata = {ned || er_q[ER_OVFL], {PAD_LA{1'b0}}, la_q};
      SEL_DA:  bus_rdata = {{PAD_DA{1'b0}}, da_q};
      SEL_ER:  bus_rdata = er_q;
      SEL_CS:  bus_rdata = cs_rd;
      SEL_WC:  bus_rdata = wc_q;
      SEL_CA:  bus_rdata = ca_q;
      SEL_MN:  bus_rdata = mn_q;
      default: bus_rdata = db_q;
    endcase
  end

  assign eng_func = func;
  assign eng_da   = da_q;
  assign eng_wc   = wc_q;
  assign eng_ca   = ca_q;

  logic unused_done;
  assign unused_done = done;

  AST_NED_AFTER_DA: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(wr_hit[SEL_DA]) && !$past(cmp_valid)) |->
      (ned == (int'(da_q[DA_W-1:DA_W-2]) >= NUM_PLATTERS))); // R5
  AST_ERR_SUMMARY: assert property (@(posedge clk) disable iff (!rst_n)
    (er_q != '0) |-> cs_rd[15]); // R2
  AST_RO_WRITE_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    ((wr_hit[SEL_ER] || wr_hit[SEL_DB]) && !cmp_valid) |=>
      ($stable(er_q) && $stable(db_q))); // R4

endmodule

// File: tb/fhd_regs_bench.sv
module fhd_regs_bench;
  import fhd_pkg::*;

  localparam int NP = 2;

  logic        clk;
  logic        rst_n;
  logic [2:0]  bus_sel;
  logic        bus_hi, bus_byte, bus_wr, bus_rd;
  logic [15:0] bus_wdata, bus_rdata;
  logic        eng_start, eng_abort, eng_inh;
  logic [1:0]  eng_func, eng_mex;
  logic [12:0] eng_da;
  logic [15:0] eng_wc, eng_ca;
  logic        cmp_valid;
  logic [4:0]  cmp_cs_err;
  logic [15:0] cmp_er, cmp_wc, cmp_ca, cmp_db;
  logic [12:0] cmp_da;
  logic [1:0]  cmp_mex;
  logic        irq;

  int n_chk;
  int n_fail;
  logic [12:0] la_exp;
  logic [15:0] v;

  fhd_regs #(.NUM_PLATTERS(NP)) u_fhd_regs (
    .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_hi(bus_hi),
    .bus_byte(bus_byte), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .eng_start(eng_start), .eng_abort(eng_abort), .eng_func(eng_func),
    .eng_da(eng_da), .eng_wc(eng_wc), .eng_ca(eng_ca), .eng_mex(eng_mex),
    .eng_inh(eng_inh), .cmp_valid(cmp_valid), .cmp_cs_err(cmp_cs_err),
    .cmp_er(cmp_er), .cmp_da(cmp_da), .cmp_wc(cmp_wc), .cmp_ca(cmp_ca),
    .cmp_mex(cmp_mex), .cmp_db(cmp_db), .irq(irq)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] sel, input logic [15:0] d,
                    input logic byt, input logic hi);
    @(negedge clk);
    bus_sel = sel; bus_wdata = d; bus_byte = byt; bus_hi = hi; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0; bus_byte = 1'b0; bus_hi = 1'b0;
  endtask

  task automatic rd(input logic [2:0] sel, output logic [15:0] d);
    @(negedge clk);
    bus_sel = sel; bus_rd = 1'b1;
    #1 d = bus_rdata;
    @(negedge clk);
    bus_rd = 1'b0;
  endtask

  task automatic rd_chk(input string req, input logic [2:0] sel, input logic [15:0] exp);
    logic [15:0] d;
    rd(sel, d);
    chk(req, d, exp);
  endtask

  task automatic la_chk(input string req, input logic flag);
    logic [15:0] d;
    rd(SEL_LA, d);
    chk(req, d, {flag, 2'b00, la_exp});
    la_exp[5:0] = la_exp[5:0] + 6'd1;
  endtask

  task automatic complete(input logic [4:0] e, input logic [15:0] er,
                          input logic [12:0] da, input logic [15:0] wc,
                          input logic [15:0] ca, input logic [1:0] mx,
                          input logic [15:0] db);
    @(negedge clk);
    cmp_cs_err = e; cmp_er = er; cmp_da = da; cmp_wc = wc;
    cmp_ca = ca; cmp_mex = mx; cmp_db = db; cmp_valid = 1'b1;
    @(negedge clk);
    cmp_valid = 1'b0;
  endtask

  initial begin
    #1_000_000;
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    n_chk = 0; n_fail = 0; la_exp = '0;
    rst_n = 1'b0; bus_sel = '0; bus_hi = 0; bus_byte = 0; bus_wr = 0; bus_rd = 0;
    bus_wdata = '0; cmp_valid = 0; cmp_cs_err = '0; cmp_er = '0; cmp_da = '0;
    cmp_wc = '0; cmp_ca = '0; cmp_mex = '0; cmp_db = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state
    chk("R1 irq", {15'b0, irq}, 16'h0);
    chk("R1 start", {15'b0, eng_start}, 16'h0);
    la_chk("R1 la", 1'b0);
    rd_chk("R1 da", SEL_DA, 16'h0);
    rd_chk("R1 er", SEL_ER, 16'h0);
    rd_chk("R1 cs", SEL_CS, 16'h0080);
    rd_chk("R1 wc", SEL_WC, 16'h0);
    rd_chk("R1 ca", SEL_CA, 16'h0);
    rd_chk("R1 mn", SEL_MN, 16'h0);
    rd_chk("R1 db", SEL_DB, 16'h0);

    // R4 ignored writes and masks
    wr(SEL_LA, 16'hFFFF, 0, 0);
    wr(SEL_ER, 16'hFFFF, 0, 0);
    wr(SEL_DB, 16'hFFFF, 0, 0);
    la_chk("R4 la ignores write", 1'b0);
    rd_chk("R4 er ignores write", SEL_ER, 16'h0);
    rd_chk("R4 db ignores write", SEL_DB, 16'h0);
    for (int i = 0; i < 16; i++) begin
      logic [15:0] pat;
      pat = 16'h1 << i;
      pat = pat | 16'h8001;
      wr(SEL_CA, pat, 0, 0);
      rd_chk("R4 ca even", SEL_CA, pat & 16'hFFFE);
      wr(SEL_MN, pat, 0, 0);
      rd_chk("R4 mn mask", SEL_MN, pat & 16'hFFC0);
    end
    wr(SEL_CA, 16'h0012, 1, 1);
    rd_chk("R4 ca byte takes word", SEL_CA, 16'h0012);

    // R3 byte lanes
    wr(SEL_WC, 16'h1234, 0, 0);
    wr(SEL_WC, 16'h00AB, 1, 1);
    rd_chk("R3 wc hi", SEL_WC, 16'hAB34);
    wr(SEL_WC, 16'h00CD, 1, 0);
    rd_chk("R3 wc lo", SEL_WC, 16'hABCD);
    wr(SEL_DA, 16'h0000, 0, 0);
    wr(SEL_DA, 16'h0007, 1, 1);
    rd_chk("R3 da hi", SEL_DA, 16'h0700);
    la_exp = 13'h0700;
    la_chk("R3 la copy", 1'b0);
    wr(SEL_DA, 16'h005A, 1, 0);
    rd_chk("R3 da lo", SEL_DA, 16'h075A);
    la_exp = 13'h075A;
    wr(SEL_CS, 16'h0040, 1, 0);
    rd_chk("R3 cs lo", SEL_CS, 16'h00C0);
    chk("R9 ie set while done", {15'b0, irq}, 16'h1);
    wr(SEL_CS, 16'h0002, 1, 1);
    rd_chk("R3 cs hi", SEL_CS, 16'h02C0);
    chk("R9 irq kept", {15'b0, irq}, 16'h1);
    wr(SEL_CS, 16'h0000, 0, 0);
    chk("R9 ie clear drops irq", {15'b0, irq}, 16'h0);
    rd_chk("R2 cs idle", SEL_CS, 16'h0080);

    // R5 unit sweep against NP platters
    for (int u = 0; u < 4; u++) begin
      logic [12:0] d;
      logic bad;
      d = 13'(u << 11) | 13'h02A5;
      bad = (u >= NP);
      wr(SEL_DA, {3'b000, d}, 0, 0);
      rd_chk("R5 da value", SEL_DA, {3'b000, d});
      rd_chk("R5 ned flag", SEL_CS, 16'h0080 | (bad ? 16'h8800 : 16'h0000));
      if (!bad) la_exp = d;
      la_chk("R6 la flag R5", bad);
    end

    // R6 rotation wrap
    wr(SEL_DA, 16'h003E, 0, 0);
    la_exp = 13'h003E;
    for (int i = 0; i < 70; i++) begin
      la_chk("R6 rotate", 1'b0);
    end
    rd_chk("R6 upper kept", SEL_LA, {3'b000, 7'h00, 6'(8'h3E + 8'd70)});
    la_exp[5:0] = la_exp[5:0] + 6'd1;

    // R7 go accepted when done
    wr(SEL_CS, 16'h0005, 0, 0);
    chk("R7 start pulse", {15'b0, eng_start}, 16'h1);
    chk("R7 func", {14'b0, eng_func}, 16'h2);
    @(negedge clk);
    chk("R7 start one cycle", {15'b0, eng_start}, 16'h0);
    rd_chk("R7 done cleared", SEL_CS, 16'h0004);
    wr(SEL_CS, 16'h0007, 0, 0);
    chk("R7 go refused busy", {15'b0, eng_start}, 16'h0);
    rd_chk("R7 busy cs", SEL_CS, 16'h0006);
    wr(SEL_CS, 16'h0044, 0, 0);
    chk("R9 no irq while busy", {15'b0, irq}, 16'h0);

    // R10 completion, transfer function
    complete(5'b0, 16'h0, 13'h0123, 16'h0000, 16'h1001, 2'b01, 16'hBEEF);
    chk("R9 irq on done rise", {15'b0, irq}, 16'h1);
    rd_chk("R10 cs", SEL_CS, 16'h00D4);
    rd_chk("R10 da", SEL_DA, 16'h0123);
    rd_chk("R10 ca", SEL_CA, 16'h1000);
    rd_chk("R10 db", SEL_DB, 16'hBEEF);
    rd_chk("R10 wc", SEL_WC, 16'h0000);
    la_exp = 13'h0123;
    la_chk("R10 la load", 1'b0);

    wr(SEL_CS, 16'h0055, 0, 0);
    chk("R7 start again", {15'b0, eng_start}, 16'h1);
    chk("R7 irq withdrawn", {15'b0, irq}, 16'h0);
    rd_chk("R7 cs busy", SEL_CS, 16'h0054);
    complete(5'b00100, 16'h0020, 13'h0200, 16'hFFF0, 16'h0000, 2'b01, 16'h0000);
    rd_chk("R2 summary", SEL_CS, 16'h90D4);
    rd_chk("R10 er or", SEL_ER, 16'h0020);
    rd_chk("R10 wc load", SEL_WC, 16'hFFF0);
    la_exp = 13'h0200;
    la_chk("R6 overflow flag", 1'b1);
    chk("R9 irq", {15'b0, irq}, 16'h1);

    wr(SEL_CS, 16'h0055, 0, 0);
    rd_chk("R7 errors cleared", SEL_CS, 16'h0054);
    rd_chk("R7 er cleared", SEL_ER, 16'h0000);
    chk("R7 irq cleared", {15'b0, irq}, 16'h0);
    la_chk("R7 la flag gone", 1'b0);

    // R8 abort
    wr(SEL_CS, 16'h0154, 0, 0);
    chk("R8 abort pulse", {15'b0, eng_abort}, 16'h1);
    chk("R8 no start", {15'b0, eng_start}, 16'h0);
    chk("R9 irq on abort", {15'b0, irq}, 16'h1);
    @(negedge clk);
    chk("R8 abort one cycle", {15'b0, eng_abort}, 16'h0);
    rd_chk("R8 done set", SEL_CS, 16'h00D4);

    // R10 position-only function keeps look-ahead
    wr(SEL_CS, 16'h0001, 0, 0);
    chk("R7 start f0", {15'b0, eng_start}, 16'h1);
    chk("R9 irq off", {15'b0, irq}, 16'h0);
    complete(5'b0, 16'h0, 13'h0456, 16'h0, 16'h0, 2'b00, 16'h0);
    rd_chk("R10 cs f0", SEL_CS, 16'h0080);
    chk("R9 no irq ie0", {15'b0, irq}, 16'h0);
    rd_chk("R10 da f0", SEL_DA, 16'h0456);
    la_chk("R10 la kept f0", 1'b0);

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

endmodule